// File: doc/BRIEF.md
# Banked Cartridge ROM Select Controller

This block models a cartridge slot that carries two banked ROM devices. Each device holds four 16 KB blocks but shows only one of them at a time through a single 16 KB window in the CPU address space. Each device keeps its own 2-bit block register. A CPU write anywhere inside the window, while that device's paged-ROM slot number is selected, loads the register with a new block number. Reads through the window return the byte at the matching offset of the block that is currently selected.

A device is chosen when the paged-ROM slot number equals `SLOT_BASE` (device 0) or `SLOT_BASE + 1` (device 1). The window is the 16 KB region whose upper two address bits equal `WIN_TAG`. The ROM contents are a computed test pattern that identifies the device and the block, so the block-switching path can be checked without a large memory. A debug port shows both block registers, so software can track the current selections.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After a synchronous reset, both block registers read 0 on `dbg_blk`, and `rd_valid` is low. A read issued after a reset returns block 0 data.
- R2: A write (`cpu_req`=1, `cpu_we`=1) with `cpu_addr[15:14]`==`WIN_TAG` and `rom_slot`==`SLOT_BASE`+n loads `cpu_wdata[1:0]` into device n's register. The new value shows on `dbg_blk[2n+1:2n]` after the next rising edge, whatever the offset `cpu_addr[13:0]` is.
- R3: Bits `cpu_wdata[7:2]` of a select write have no effect on the loaded block number.
- R4: A select write to one device never changes the other device's register.
- R5: An access outside the window, or with a slot number that matches neither device, changes no register and produces no `rd_valid`.
- R6: A read (`cpu_req`=1, `cpu_we`=0) that hits device n returns, one cycle later with `rd_valid`=1, the byte {n[0], blk[1:0], o[4:0] ^ o[9:5] ^ {1'b0,o[13:10]}}. Here o is `cpu_addr[13:0]` and blk is the register value from before that cycle's edge.
- R7: A block selection persists: repeated reads at different offsets keep returning data from the same block until the next select write to that device.
- R8: While `rd_valid` is low, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Bus access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write (block select), 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | Write data; low two bits give the block number |
| rom_slot | input | 4 | Paged-ROM slot number currently selected |
| rd_data | output | 8 | Registered read data, 0 when not valid |
| rd_valid | output | 1 | Read data valid, one cycle after a read hit |
| dbg_blk | output | 4 | Block registers, device 0 in [1:0], device 1 in [3:2] |

## Verification
The bench writes every block number to each device through different window offsets. It puts junk in the upper data bits, and it reads back pattern bytes in which the block field would expose a register that loaded the wrong bits or took its value from the address. It places a read directly after a write, to catch a design that reads with a stale or too-early block value. It aims writes at the neighbouring slot, at a slot that is not decoded, and at an address outside the window, to catch cross-talk between the two registers and missing decode terms. A reset in the middle of the run, taken while both registers hold nonzero blocks, must bring back block 0. A register that ignored the reset would return the old block's data.

// File: rtl/cart_pkg.sv
package cart_pkg;

    localparam int ADDR_W    = 16;
    localparam int OFF_W     = 14;
    localparam int BLK_W     = 2;
    localparam int DATA_W    = 8;
    localparam int SLOT_W    = 4;
    localparam int NUM_CHIPS = 2;
    localparam int TAG_W     = ADDR_W - OFF_W;

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic                 rd_hit;
        logic                 wr_hit;
        logic [NUM_CHIPS-1:0] cs;
        off_t                 off;
    } bus_dec_t;

    // Pattern content: chip id, block number, folded offset.
    function automatic byte_t pattern_byte(input logic chip, input blk_t blk, input off_t off);
        logic [4:0] fold;
        fold = off[4:0] ^ off[9:5] ^ {1'b0, off[13:10]};
        return {chip, blk, fold};
    endfunction

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_pkg::*;
#(
    parameter logic [SLOT_W-1:0] SLOT_BASE = 4'd4,
    parameter logic [TAG_W-1:0]  WIN_TAG   = 2'b10
) (
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [SLOT_W-1:0] rom_slot,
    output bus_dec_t          dec
);

    logic                 in_win;
    logic [NUM_CHIPS-1:0] cs_vec;

    assign in_win = cpu_req && (cpu_addr[ADDR_W-1:OFF_W] == WIN_TAG);

    for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_cs
        assign cs_vec[i] = in_win && (rom_slot == SLOT_W'(SLOT_BASE + i));
    end

    always_comb begin
        dec.cs     = cs_vec;
        dec.off    = cpu_addr[OFF_W-1:0];
        dec.wr_hit = (|cs_vec) && cpu_we;
        dec.rd_hit = (|cs_vec) && !cpu_we;
    end

endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg
    import cart_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  blk_t wr_blk,
    output blk_t blk
);

    blk_t blk_q;

    always_ff @(posedge clk) begin
        if (rst)        blk_q <= '0;
        else if (wr_en) blk_q <= wr_blk;
    end

    assign blk = blk_q;

    AST_BLK_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (blk == $past(wr_blk))); // R2

    AST_BLK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(blk)); // R7

endmodule

// File: rtl/cart_pattern_rom.sv
module cart_pattern_rom
    import cart_pkg::*;
#(
    parameter int CHIP_ID = 0
) (
    input  blk_t  blk,
    input  off_t  off,
    output byte_t data
);

    localparam logic CHIP_BIT = 1'(CHIP_ID);

    assign data = pattern_byte(CHIP_BIT, blk, off);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_pkg::*;
#(
    parameter logic [SLOT_W-1:0] SLOT_BASE = 4'd4,
    parameter logic [TAG_W-1:0]  WIN_TAG   = 2'b10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    input  logic [SLOT_W-1:0]          rom_slot,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic [NUM_CHIPS*BLK_W-1:0] dbg_blk
);

    bus_dec_t dec;
    blk_t     blk_arr  [NUM_CHIPS];
    byte_t    rom_arr  [NUM_CHIPS];
    byte_t    rd_mux;
    byte_t    rd_data_q;
    logic     rd_valid_q;
    logic     unused_wdata_hi;

    assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:BLK_W];

    cart_addr_decode #(
        .SLOT_BASE (SLOT_BASE),
        .WIN_TAG   (WIN_TAG)
    ) u_dec (
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .rom_slot (rom_slot),
        .dec      (dec)
    );

    for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_chip
        cart_bank_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (dec.wr_hit && dec.cs[i]),
            .wr_blk (cpu_wdata[BLK_W-1:0]),
            .blk    (blk_arr[i])
        );

        cart_pattern_rom #(.CHIP_ID(i)) u_rom (
            .blk  (blk_arr[i]),
            .off  (dec.off),
            .data (rom_arr[i])
        );

        assign dbg_blk[i*BLK_W +: BLK_W] = blk_arr[i];
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CHIPS; i++) begin
            rd_mux = rd_mux | (rom_arr[i] & {DATA_W{dec.cs[i]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= dec.rd_hit;
            rd_data_q  <= dec.rd_hit ? rd_mux : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && (cpu_addr[ADDR_W-1:OFF_W] == WIN_TAG)
         && (rom_slot == SLOT_BASE)) |=> rd_valid); // R6

    AST_NO_STRAY_READ: assert property (@(posedge clk) disable iff (rst)
        (!cpu_req || cpu_we || (cpu_addr[ADDR_W-1:OFF_W] != WIN_TAG)) |=> !rd_valid); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)); // R8

endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [3:0]  rom_slot = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [3:0]  dbg_blk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic [1:0] model_blk [2];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    cart_bank_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .rom_slot  (rom_slot),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .dbg_blk   (dbg_blk)
    );

    function automatic logic [7:0] expect_byte(input int chip, input logic [1:0] blk, input logic [13:0] o);
        logic [4:0] f;
        f = o[4:0] ^ o[9:5] ^ {1'b0, o[13:10]};
        return {chip[0], blk, f};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses appear.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected rd_valid", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, int'(rd_data), int'(e));
            end
        end
    end

    // Driver: one access then one idle cycle.
    task automatic bus_op(input bit we, input logic [15:0] a, input logic [7:0] d,
                          input logic [3:0] slot, input string tag);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; rom_slot = slot;
        if (a[15:14] == 2'b10 && (slot == 4'd4 || slot == 4'd5)) begin
            int c;
            c = (slot == 4'd5) ? 1 : 0;
            if (we) model_blk[c] = d[1:0];
            else begin
                exp_q.push_back(expect_byte(c, model_blk[c], a[13:0]));
                tag_q.push_back(tag);
            end
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic check_dbg(input string req);
        logic [3:0] e;
        e = {model_blk[1], model_blk[0]};
        check(dbg_blk == e, req, int'(dbg_blk), int'(e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_req = 1'b0;
        model_blk[0] = 2'd0; model_blk[1] = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        model_blk[0] = 2'd0; model_blk[1] = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dbg_blk == 4'h0, "R1 reset blocks", int'(dbg_blk), 0);
        check(rd_valid == 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
        check(rd_data == 8'h00, "R8 idle data", int'(rd_data), 0);

        bus_op(1'b0, 16'h8123, 8'h00, 4'd4, "R1 read block0 after reset");
        bus_op(1'b0, 16'hBFFF, 8'h00, 4'd5, "R1 read chip1 block0");

        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < 4; b++) begin
                logic [13:0] off;
                logic [7:0]  d;
                off = 14'((b * 14'h1357 + c * 14'h0AB1) & 14'h3FFF);
                d   = {6'(8'hA5 >> b) ^ 6'(c * 6'h2A), 2'(b)};
                bus_op(1'b1, {2'b10, off}, d, 4'(4 + c), "R2 write");
                check_dbg("R2/R3/R4 select write");
                check(rd_data == 8'h00, "R8 idle after write", int'(rd_data), 0);
                bus_op(1'b0, {2'b10, 14'(off ^ 14'h2AAA)}, 8'h00, 4'(4 + c), "R6 read pattern");
                bus_op(1'b0, 16'h8000, 8'h00, 4'(4 + c), "R7 block persists");
                bus_op(1'b0, {2'b10, 14'h3C3C}, 8'h00, 4'(5 - c), "R4 other chip data");
            end
        end

        // Misses: wrong slot, outside window.
        bus_op(1'b1, 16'h8004, 8'hFE, 4'd7, "R5 write unknown slot");
        check_dbg("R5 slot miss keeps blocks");
        bus_op(1'b1, 16'h4004, 8'hFD, 4'd4, "R5 write outside window");
        check_dbg("R5 window miss keeps blocks");
        bus_op(1'b0, 16'hC010, 8'h00, 4'd5, "R5 read outside window");
        check(rd_valid == 1'b0, "R5 no rd_valid for miss", int'(rd_valid), 0);

        // Back-to-back: write immediately followed by read.
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h9999; cpu_wdata = 8'hF1; rom_slot = 4'd4;
        model_blk[0] = 2'd1;
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 16'hA5A5;
        exp_q.push_back(expect_byte(0, 2'd1, 14'h25A5));
        tag_q.push_back("R6 read right after write");
        @(negedge clk);
        cpu_req = 1'b0;
        check_dbg("R3 upper data ignored");

        // Mid-run reset with nonzero blocks.
        bus_op(1'b1, 16'h8000, 8'h03, 4'd5, "R2 write");
        check_dbg("R2 chip1 block3");
        do_reset();
        @(negedge clk);
        check(dbg_blk == 4'h0, "R1 reset restores block0", int'(dbg_blk), 0);
        bus_op(1'b0, 16'h8ABC, 8'h00, 4'd4, "R1 chip0 data after reset");
        bus_op(1'b0, 16'h8ABC, 8'h00, 4'd5, "R1 chip1 data after reset");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule